// File: doc/BRIEF.md
# Folded SRAM Array Organizer

A synchronous behavioural memory in which the storage is laid out as a small number of wide physical rows and not as one word per entry. Each row holds 2^C logical words of M bits. The high-order address bits select a row through a predecoded one-hot row decoder. The low-order bits steer M independent 2^C:1 column multiplexers, one per data bit, so that one word is picked out of the fetched row.

A read behaves like a precharged bitline array. Every bitline idles high. The selected wordline pulls down the bitlines whose cells hold zero, and the column muxes route the addressed slot to a register that drives the read port one cycle later. A write opens the same wordline and changes only the M bits of the addressed slot. All other slots in that row keep their contents. The default shape is 2048 x 16, held as 256 rows of 128 bits. The 4-row, 2-bit-word shape is also supported.

Top module: `folded_sram`

## Requirements
- R1: The address splits into a column field in the low C bits and a row field in the high R bits. Bit b of the word in column slot j sits at bit j*M+b of row (address >> C). Every address therefore reaches its own word.
- R2: When a cycle has ce_i=1 and we_i=0, rdata_o shows the word stored at addr_i from the rising edge that ends that cycle onwards (one cycle of latency).
- R3: When a cycle has ce_i=1 and we_i=1, wdata_i is stored at addr_i. A later read of that address returns it.
- R4: While ce_i=1, exactly one row-decoder output is active, namely the one numbered addr_i[N-1:C]. While ce_i=0, no row-decoder output is active.
- R5: A write changes only the M bits of the addressed slot. The other slots of the same row and all other rows keep their values.
- R6: While ce_i=0, rdata_o holds its value and the storage does not change, whatever we_i, addr_i and wdata_i are.
- R7: During a write cycle, rdata_o keeps the value it had before that cycle.
- R8: While rst_ni is low, and after reset until the first read, rdata_o is zero.
- R9: The same behaviour holds for the small shape M=2, R=2, C=1 (8 words, 16 stored bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset of the read register, active low |
| ce_i | input | 1 | Chip enable; opens a wordline |
| we_i | input | 1 | 1 = write, 0 = read, when ce_i=1 |
| addr_i | input | R+C | Word address: row field high, column field low |
| wdata_i | input | M | Write data |
| rdata_o | output | M | Registered read data |

## Verification
The bound checker enforces the row-decoder invariants on every cycle: one-hot while enabled, idle while disabled, and the active row matching the high address field. It also enforces that rdata_o stays stable after idle and write cycles. Whether the column slot bit placement is correct, whether a write leaves neighbouring slots intact, and whether read data matches what was stored can only be shown by the bench. The bench does this with a full fill and readback, directed row-sharing writes and seeded random traffic in both the default shape and the small shape.

// File: rtl/folded_sram_pkg.sv
`timescale 1ns/1ps
package folded_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/fsa_row_decoder.sv
`timescale 1ns/1ps
// Predecoded 1-to-2^R decoder: G-bit groups become one-hot terms, rows AND one term per group.
module fsa_row_decoder #(
  parameter int R = 8,
  parameter int G = 2
) (
  input  logic              en_i,
  input  logic [R-1:0]      row_i,
  output logic [(1<<R)-1:0] sel_o
);
  localparam int ROWS = 1 << R;
  localparam int NG   = (R + G - 1) / G;
  localparam int T    = 1 << G;

  logic [NG*T-1:0] pd;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = g * G;
    localparam int GW = (R - LO < G) ? (R - LO) : G;
    logic [T-1:0] term;
    always_comb begin
      term = '0;
      term[row_i[LO +: GW]] = 1'b1;
    end
    assign pd[g*T +: T] = term;
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      logic acc;
      acc = en_i;
      for (int g = 0; g < NG; g++) begin
        acc = acc & pd[g*T + ((r >> (g*G)) & (T-1))];
      end
      sel_o[r] = acc;
    end
  end
endmodule

// File: rtl/fsa_bitcell_array.sv
`timescale 1ns/1ps
// Wide-row storage: bitlines idle high, the open wordline pulls down zero cells.
module fsa_bitcell_array #(
  parameter int M = 16,
  parameter int R = 8,
  parameter int C = 3
) (
  input  logic                    clk_i,
  input  logic [(1<<R)-1:0]       wl_i,
  input  logic                    wr_i,
  input  logic [C-1:0]            col_i,
  input  logic [M-1:0]            wdata_i,
  output logic [(M<<C)-1:0]       bl_o
);
  localparam int ROWS = 1 << R;
  localparam int W    = M << C;
  localparam int SLOTS = 1 << C;

  logic [W-1:0] mem [ROWS];
  logic [W-1:0] slot_mask;
  logic [W-1:0] wide_data;

  assign slot_mask = {{(W-M){1'b0}}, {M{1'b1}}} << (int'(col_i) * M);
  assign wide_data = {SLOTS{wdata_i}};

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      for (int r = 0; r < ROWS; r++) begin
        if (wl_i[r]) mem[r] <= (mem[r] & ~slot_mask) | (wide_data & slot_mask);
      end
    end
  end

  always_comb begin
    bl_o = '1;
    for (int r = 0; r < ROWS; r++) begin
      if (wl_i[r]) bl_o = bl_o & mem[r];
    end
  end
endmodule

// File: rtl/fsa_col_mux.sv
`timescale 1ns/1ps
// One 2^C:1 mux per output bit; tap j of bit b is row bit j*M+b.
module fsa_col_mux #(
  parameter int M = 16,
  parameter int C = 3
) (
  input  logic [(M<<C)-1:0] row_i,
  input  logic [C-1:0]      sel_i,
  output logic [M-1:0]      word_o
);
  localparam int SLOTS = 1 << C;

  for (genvar b = 0; b < M; b++) begin : g_bit
    logic [SLOTS-1:0] taps;
    for (genvar j = 0; j < SLOTS; j++) begin : g_tap
      assign taps[j] = row_i[j*M + b];
    end
    assign word_o[b] = taps[sel_i];
  end
endmodule

// File: rtl/folded_sram.sv
`timescale 1ns/1ps
module folded_sram
  import folded_sram_pkg::*;
#(
  parameter int M = 16,
  parameter int R = 8,
  parameter int C = 3,
  localparam int N = R + C
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         we_i,
  input  logic [N-1:0] addr_i,
  input  logic [M-1:0] wdata_i,
  output logic [M-1:0] rdata_o
);
  localparam int ROWS = 1 << R;
  localparam int W    = M << C;

  op_e              op;
  logic [ROWS-1:0]  row_sel;
  logic [W-1:0]     bitlines;
  logic [M-1:0]     mux_word;

  always_comb begin
    if (!ce_i)     op = OP_IDLE;
    else if (we_i) op = OP_WRITE;
    else           op = OP_READ;
  end

  fsa_row_decoder #(.R(R), .G(2)) u_rdec (
    .en_i  (ce_i),
    .row_i (addr_i[N-1:C]),
    .sel_o (row_sel)
  );

  fsa_bitcell_array #(.M(M), .R(R), .C(C)) u_array (
    .clk_i   (clk_i),
    .wl_i    (row_sel),
    .wr_i    (op == OP_WRITE),
    .col_i   (addr_i[C-1:0]),
    .wdata_i (wdata_i),
    .bl_o    (bitlines)
  );

  fsa_col_mux #(.M(M), .C(C)) u_cmux (
    .row_i  (bitlines),
    .sel_i  (addr_i[C-1:0]),
    .word_o (mux_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (op == OP_READ)  rdata_o <= mux_word;
  end
endmodule

// File: rtl/fsa_checker.sv
`timescale 1ns/1ps
module fsa_checker #(
  parameter int M = 16,
  parameter int R = 8,
  parameter int C = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ce_i,
  input logic               we_i,
  input logic [R+C-1:0]     addr_i,
  input logic [M-1:0]       rdata_o,
  input logic [(1<<R)-1:0]  row_sel
);
  AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |-> $countones(row_sel) == 1); // R4
  AST_ROW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |-> row_sel == '0); // R4
  AST_ROW_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |-> row_sel[addr_i[R+C-1:C]]); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(rdata_o)); // R6
  AST_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && we_i) |=> $stable(rdata_o)); // R7
  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (rdata_o == '0); // R8
  end
endmodule

bind folded_sram fsa_checker #(.M(M), .R(R), .C(C)) u_fsa_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_i    (ce_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .row_sel (row_sel)
);

// File: tb/folded_sram_bench.sv
`timescale 1ns/1ps
module folded_sram_bench;
  localparam int M = 16, R = 8, C = 3, N = R + C, WORDS = 1 << N;
  localparam int SM = 2, SR = 2, SC = 1, SN = SR + SC, SWORDS = 1 << SN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic ce, we;
  logic [N-1:0] addr;
  logic [M-1:0] wdata, rdata;
  logic s_ce, s_we;
  logic [SN-1:0] s_addr;
  logic [SM-1:0] s_wdata, s_rdata;

  folded_sram #(.M(M), .R(R), .C(C)) u_folded_sram (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  folded_sram #(.M(SM), .R(SR), .C(SC)) u_folded_sram_small (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(s_ce), .we_i(s_we),
    .addr_i(s_addr), .wdata_i(s_wdata), .rdata_o(s_rdata));

  logic [M-1:0]  model [WORDS];
  logic [SM-1:0] s_model [SWORDS];
  logic [M-1:0]  exp_rd = '0;
  logic [SM-1:0] s_exp_rd = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [M-1:0] pat(int a);
    return M'((a * 40503) ^ (a >> 3) ^ 16'h5a3c);
  endfunction

  task automatic check(string tag, logic [M-1:0] act, logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit c, bit w, int a, logic [M-1:0] d, string tag);
    @(negedge clk);
    ce = c; we = w; addr = N'(a); wdata = d;
    @(posedge clk);
    #1;
    if (c && !w) exp_rd = model[a];
    if (c && w) model[a] = d;
    check(tag, rdata, exp_rd);
  endtask

  task automatic s_step(bit c, bit w, int a, logic [SM-1:0] d, string tag);
    @(negedge clk);
    s_ce = c; s_we = w; s_addr = SN'(a); s_wdata = d;
    @(posedge clk);
    #1;
    if (c && !w) s_exp_rd = s_model[a];
    if (c && w) s_model[a] = d;
    check(tag, M'(s_rdata), M'(s_exp_rd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    ce = 0; we = 0; addr = '0; wdata = '0;
    s_ce = 0; s_we = 0; s_addr = '0; s_wdata = '0;
    repeat (3) @(negedge clk);
    check("R8 reset", rdata, '0);
    check("R8 reset small", M'(s_rdata), '0);
    rst_n = 1'b1;

    // fill: every write must leave rdata untouched
    for (int a = 0; a < WORDS; a++) step(1, 1, a, pat(a), "R3 R7 fill write");
    for (int a = 0; a < WORDS; a++) step(1, 0, a, 'x, "R1 R2 R4 readback");

    // neighbours in one row survive a slot write
    for (int j = 0; j < (1 << C); j++) begin
      step(1, 1, (5 << C) | j, ~pat((5 << C) | j), "R5 slot write");
      for (int k = 0; k < (1 << C); k++) step(1, 0, (5 << C) | k, 'x, "R5 row neighbours");
      step(1, 0, (6 << C) | j, 'x, "R5 next row");
    end
    step(1, 1, 9, 16'hffff, "R5 ones");
    step(1, 1, 10, 16'h0000, "R5 zeros");
    for (int k = 8; k < 16; k++) step(1, 0, k, 'x, "R5 mixed row");

    // idle cycles: output holds, storage untouched
    step(1, 0, 77, 'x, "R2 pre-idle read");
    step(0, 1, 77, 16'hdead, "R6 idle hold");
    step(0, 0, 300, 16'hbeef, "R6 idle hold");
    // model must not take the idle write: undo by construction of step (ce=0 skips)
    step(1, 0, 77, 'x, "R6 storage untouched");
    step(1, 0, WORDS - 1, 'x, "R1 top address");
    step(1, 0, 0, 'x, "R1 bottom address");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit c, w;
      c = ($urandom % 4) != 0;
      w = ($urandom % 2) != 0;
      step(c, w, int'($urandom % WORDS), M'($urandom), c ? (w ? "R3 R7 random write" : "R2 random read") : "R6 random idle");
    end

    // small shape
    for (int a = 0; a < SWORDS; a++) s_step(1, 1, a, SM'(a ^ 2), "R9 small write");
    for (int a = 0; a < SWORDS; a++) s_step(1, 0, a, 'x, "R9 small readback");
    s_step(1, 1, 3, 2'b11, "R9 small slot write");
    s_step(1, 0, 2, 'x, "R9 small neighbour");
    s_step(1, 0, 3, 'x, "R9 small written");
    s_step(0, 1, 3, 2'b00, "R9 small idle");
    s_step(1, 0, 3, 'x, "R9 small idle untouched");
    for (int i = 0; i < 400; i++) begin
      bit c, w;
      c = ($urandom % 4) != 0;
      w = ($urandom % 2) != 0;
      s_step(c, w, int'($urandom % SWORDS), SM'($urandom), "R9 small random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule